// File: doc/BRIEF.md
# Integer ALU with Two-Level Operation Decoder

This block holds the arithmetic and logic unit of a simple 32-bit processor datapath together with the small decoder that picks its operation. The decoder takes a 2-bit operation class from the main instruction decoder and the 6-bit function field of a register-register instruction. It returns a 3-bit operation code. The class either forces an addition (address arithmetic for loads, stores and immediates), forces a subtraction (equality compare for branches), or hands the choice to the function field.

The ALU receives two operands and a 3-bit operation code. It returns a 32-bit result and a flag that is high when that result is zero. Bit 2 of the code swaps operand B for its complement and sets the adder's carry-in. One adder therefore serves both addition and subtraction, and the logic unit gains AND-with-complement and OR-with-complement for free. The code output of the decoder and the code input of the ALU are separate ports. The integrating datapath can then wire them directly, or register the code when control runs a stage ahead of execution. Both halves are purely combinational.

Top module: `alu_unit`

## Requirements
- R1: With operation class 00 the decoder outputs code 010 (add), for any function field value.
- R2: With operation class 01 or 11 (bit 0 set) the decoder outputs code 110 (subtract), for any function field value.
- R3: With operation class 10 the decoder maps function field 100000 to 010, 100010 to 110, 100100 to 000, 100101 to 001 and 101010 to 111.
- R4: With operation class 10 and any function field value not listed in R3, the decoder outputs code 011.
- R5: Code 000 yields A AND B, and code 001 yields A OR B.
- R6: Code 010 yields A + B modulo 2^32.
- R7: Code 110 yields A - B modulo 2^32, formed as A + ~B + 1.
- R8: Code 100 yields A AND NOT B, and code 101 yields A OR NOT B.
- R9: Code 111 yields 1 when A is less than B as signed two's-complement values and 0 otherwise, including the case where A - B overflows.
- R10: Code 011 yields a result of 0.
- R11: The zero output is 1 exactly when the 32-bit result equals 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| alu_op_i | input | 2 | Operation class from the main decoder |
| funct_i | input | 6 | Function field of the instruction |
| ctl_o | output | 3 | Operation code chosen by the decoder |
| ctl_i | input | 3 | Operation code applied to the ALU |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| result_o | output | 32 | ALU result |
| zero_o | output | 1 | High when result_o is zero |

## Verification
The immediate assertions assume that every input is a known 0 or 1 when the block is evaluated. Each assertion checks the decoder or the ALU against its own current inputs, so the assertions make no assumption about any ordering between the decoder output and the ALU input. The stimulus drives all inputs to defined values before the first comparison and changes them only at the falling clock edge. It covers every operation class, every listed function value and several unlisted ones, all eight codes, and the operand pairs that make signed compare overflow or make the result wrap to zero.

// File: rtl/alu_pkg.sv
// Shared types for the ALU and its operation decoder.
// Assumes a 3-bit operation code whose bit 2 means "use complement of B".
package alu_pkg;
    localparam int unsigned CTL_W   = 3;
    localparam int unsigned OP_W    = 2;
    localparam int unsigned FUNCT_W = 6;

    // ALU operation codes; bit 2 selects inverted B, bits 1:0 the unit.
    typedef enum logic [CTL_W-1:0] {
        CTL_AND  = 3'b000,
        CTL_OR   = 3'b001,
        CTL_ADD  = 3'b010,
        CTL_NONE = 3'b011,
        CTL_ANDN = 3'b100,
        CTL_ORN  = 3'b101,
        CTL_SUB  = 3'b110,
        CTL_SLT  = 3'b111
    } alu_ctl_e;

    // Function field values recognised under the register-register class.
    localparam logic [FUNCT_W-1:0] FN_ADD = 6'b100000;
    localparam logic [FUNCT_W-1:0] FN_SUB = 6'b100010;
    localparam logic [FUNCT_W-1:0] FN_AND = 6'b100100;
    localparam logic [FUNCT_W-1:0] FN_OR  = 6'b100101;
    localparam logic [FUNCT_W-1:0] FN_SLT = 6'b101010;

    // Map a function field onto an operation code; unknown gives CTL_NONE.
    function automatic alu_ctl_e funct_to_ctl(input logic [FUNCT_W-1:0] fn);
        alu_ctl_e c;
        case (fn)
            FN_ADD:  c = CTL_ADD;
            FN_SUB:  c = CTL_SUB;
            FN_AND:  c = CTL_AND;
            FN_OR:   c = CTL_OR;
            FN_SLT:  c = CTL_SLT;
            default: c = CTL_NONE;
        endcase
        return c;
    endfunction
endpackage

// File: rtl/alu_ctl_decode.sv
// Second-level operation decoder.
// Turns the 2-bit operation class and the function field into an ALU code.
// Assumes class bit 0 has priority: any class with bit 0 set means subtract.
module alu_ctl_decode
    import alu_pkg::*;
(
    input  logic [OP_W-1:0]    alu_op_i,
    input  logic [FUNCT_W-1:0] funct_i,
    output logic [CTL_W-1:0]   ctl_o
);
    alu_ctl_e ctl;

    // Pick forced add, forced subtract, or the function-field operation.
    always_comb begin
        if (alu_op_i[0]) begin
            ctl = CTL_SUB;
        end else if (alu_op_i[1]) begin
            ctl = funct_to_ctl(funct_i);
        end else begin
            ctl = CTL_ADD;
        end
    end

    assign ctl_o = ctl;

    // Guard the decoder contract at its ports.
    always_comb begin
        if (alu_op_i == 2'b00) begin
            p_class_add_r1: assert (ctl_o == 3'b010)
                else $error("class 00 gave code %b", ctl_o);
        end
        if (alu_op_i[0]) begin
            p_class_sub_r2: assert (ctl_o == 3'b110)
                else $error("class x1 gave code %b", ctl_o);
        end
        if (alu_op_i == 2'b10 && funct_i == 6'b101010) begin
            p_funct_slt_r3: assert (ctl_o == 3'b111)
                else $error("slt funct gave code %b", ctl_o);
        end
        if (alu_op_i == 2'b10 && funct_i[5] == 1'b0) begin
            p_funct_unknown_r4: assert (ctl_o == 3'b011)
                else $error("unknown funct gave code %b", ctl_o);
        end
    end
endmodule

// File: rtl/alu_bcond.sv
// Operand B conditioning: passes B or its bitwise complement.
// Assumes the invert request comes from bit 2 of the operation code.
module alu_bcond #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] b_i,
    input  logic             invert_i,
    output logic [WIDTH-1:0] b_o
);
    // Per-bit conditional inversion.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign b_o[i] = b_i[i] ^ invert_i;
    end
endmodule

// File: rtl/alu_addsub.sv
// Shared adder for add, subtract and signed less-than.
// Assumes B is already conditioned; carry-in equals the invert request.
module alu_addsub #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] bc_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             less_o
);
    localparam int unsigned MSB = WIDTH - 1;

    logic ovf;

    // Sum with carry-in; a subtract is A + ~B + 1.
    assign sum_o = a_i + bc_i + {{(WIDTH-1){1'b0}}, cin_i};

    // Signed overflow: like-signed inputs whose sum changes sign.
    assign ovf = (a_i[MSB] ~^ bc_i[MSB]) & (sum_o[MSB] ^ a_i[MSB]);

    // Less-than is the sign of the difference, corrected for overflow.
    assign less_o = sum_o[MSB] ^ ovf;
endmodule

// File: rtl/alu_logic.sv
// Bitwise logic unit: AND or OR of A with the conditioned B.
// Assumes B is already conditioned by the inversion stage.
module alu_logic #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] bc_i,
    input  logic             sel_or_i,
    output logic [WIDTH-1:0] y_o
);
    // Select OR or AND of the operands.
    assign y_o = sel_or_i ? (a_i | bc_i) : (a_i & bc_i);
endmodule

// File: rtl/alu_unit.sv
// Integer ALU with its operation decoder.
// The decoder code is brought out on ctl_o; the ALU executes ctl_i.
// Assumes all inputs are defined; purely combinational, no state.
module alu_unit
    import alu_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [1:0]       alu_op_i,
    input  logic [5:0]       funct_i,
    output logic [2:0]       ctl_o,
    input  logic [2:0]       ctl_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] result_o,
    output logic             zero_o
);
    localparam logic [WIDTH-1:0] ZERO_W = '0;

    alu_ctl_e         code;
    logic [WIDTH-1:0] b_cond;
    logic [WIDTH-1:0] sum;
    logic             less;
    logic [WIDTH-1:0] logic_y;

    assign code = alu_ctl_e'(ctl_i);

    alu_ctl_decode u_dec (
        .alu_op_i (alu_op_i),
        .funct_i  (funct_i),
        .ctl_o    (ctl_o)
    );

    alu_bcond #(.WIDTH(WIDTH)) u_bcond (
        .b_i      (b_i),
        .invert_i (ctl_i[2]),
        .b_o      (b_cond)
    );

    alu_addsub #(.WIDTH(WIDTH)) u_add (
        .a_i    (a_i),
        .bc_i   (b_cond),
        .cin_i  (ctl_i[2]),
        .sum_o  (sum),
        .less_o (less)
    );

    alu_logic #(.WIDTH(WIDTH)) u_logic (
        .a_i      (a_i),
        .bc_i     (b_cond),
        .sel_or_i (ctl_i[0]),
        .y_o      (logic_y)
    );

    // Route the unit chosen by code bits 1:0 onto the result.
    always_comb begin
        case (ctl_i[1:0])
            2'b00, 2'b01: result_o = logic_y;
            2'b10:        result_o = sum;
            default:      result_o = ctl_i[2] ? {{(WIDTH-1){1'b0}}, less} : ZERO_W;
        endcase
    end

    // Zero flag from a reduction over the result.
    assign zero_o = ~|result_o;

    // Guard the ALU contract at its ports.
    always_comb begin
        if (code == CTL_AND) begin
            p_and_r5: assert (result_o == (a_i & b_i))
                else $error("and mismatch");
        end
        if (code == CTL_ADD) begin
            p_add_r6: assert (result_o == WIDTH'(a_i + b_i))
                else $error("add mismatch");
        end
        if (code == CTL_SUB) begin
            p_sub_r7: assert (result_o == WIDTH'(a_i - b_i))
                else $error("sub mismatch");
        end
        if (code == CTL_ORN) begin
            p_orn_r8: assert (result_o == (a_i | ~b_i))
                else $error("or-not mismatch");
        end
        if (code == CTL_SLT) begin
            p_slt_r9: assert (result_o == {{(WIDTH-1){1'b0}}, ($signed(a_i) < $signed(b_i))})
                else $error("slt mismatch");
        end
        if (code == CTL_NONE) begin
            p_unused_r10: assert (result_o == ZERO_W)
                else $error("unused code gave nonzero");
        end
        p_zero_r11: assert (zero_o == (result_o == ZERO_W))
            else $error("zero flag mismatch");
    end
endmodule

// File: tb/alu_unit_test.sv
// Scoreboard bench: the driver pushes expected items, the monitor pops and compares.
module alu_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int W          = 32;

    typedef struct {
        string        tag;
        logic [2:0]   ectl;
        logic [W-1:0] eres;
        logic         ez;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   alu_op;
    logic [5:0]   funct;
    logic [2:0]   ctl_out;
    logic [2:0]   ctl_in;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] result;
    logic         zero;

    int     checks = 0;
    int     errors = 0;
    bit     done   = 1'b0;
    item_t  sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_unit uut (
        .alu_op_i (alu_op),
        .funct_i  (funct),
        .ctl_o    (ctl_out),
        .ctl_i    (ctl_in),
        .a_i      (a),
        .b_i      (b),
        .result_o (result),
        .zero_o   (zero)
    );

    // Expected decoder code from R1..R4.
    function automatic logic [2:0] ref_ctl(input logic [1:0] op, input logic [5:0] fn);
        if (op[0])            return 3'b110;
        if (op == 2'b00)      return 3'b010;
        if (fn == 6'b100000)  return 3'b010;
        if (fn == 6'b100010)  return 3'b110;
        if (fn == 6'b100100)  return 3'b000;
        if (fn == 6'b100101)  return 3'b001;
        if (fn == 6'b101010)  return 3'b111;
        return 3'b011;
    endfunction

    // Expected result from R5..R10.
    function automatic logic [W-1:0] ref_res(input logic [2:0] c, input logic [W-1:0] x, input logic [W-1:0] y);
        case (c)
            3'b000: return x & y;
            3'b001: return x | y;
            3'b010: return x + y;
            3'b100: return x & ~y;
            3'b101: return x | ~y;
            3'b110: return x - y;
            3'b111: return ($signed(x) < $signed(y)) ? 1 : 0;
            default: return '0;
        endcase
    endfunction

    // Driver: apply one vector at the falling edge and queue its expectation.
    task automatic drive(input string tag, input logic [1:0] op, input logic [5:0] fn,
                         input logic [2:0] c, input logic [W-1:0] x, input logic [W-1:0] y);
        item_t it;
        @(negedge clk);
        alu_op = op; funct = fn; ctl_in = c; a = x; b = y;
        it.tag  = tag;
        it.ectl = ref_ctl(op, fn);
        it.eres = ref_res(c, x, y);
        it.ez   = (it.eres == '0);
        sb.push_back(it);
    endtask

    // Monitor: compare the oldest expectation at the rising edge.
    always @(posedge clk) begin
        if (rst_n && sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks += 3;
            if (ctl_out !== it.ectl) begin
                errors++;
                $display("FAIL %s ctl got %b exp %b", it.tag, ctl_out, it.ectl);
            end
            if (result !== it.eres) begin
                errors++;
                $display("FAIL %s result got %h exp %h", it.tag, result, it.eres);
            end
            if (zero !== it.ez) begin
                errors++;
                $display("FAIL %s (R11) zero got %b exp %b", it.tag, zero, it.ez);
            end
        end
    end

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        alu_op = 2'b00; funct = '0; ctl_in = 3'b000; a = '0; b = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // Idle state: all-zero inputs give add code and a zero result (R1, R11).
        drive("R1 idle", 2'b00, 6'h00, 3'b000, 32'h0, 32'h0);

        // R1: class 00 ignores funct.
        drive("R1", 2'b00, 6'b100010, 3'b010, 32'h0000_0005, 32'h0000_0003);
        drive("R1", 2'b00, 6'b111111, 3'b010, 32'hFFFF_FFFF, 32'h0000_0001);
        // R2: class 01 and 11 force subtract.
        drive("R2", 2'b01, 6'b100000, 3'b110, 32'h0000_0007, 32'h0000_0007);
        drive("R2", 2'b11, 6'b100100, 3'b110, 32'h0000_0001, 32'h0000_0002);
        // R3: every listed funct under class 10.
        drive("R3 add", 2'b10, 6'b100000, 3'b010, 32'h1234_5678, 32'h1111_1111);
        drive("R3 sub", 2'b10, 6'b100010, 3'b110, 32'h1234_5678, 32'h1111_1111);
        drive("R3 and", 2'b10, 6'b100100, 3'b000, 32'hF0F0_F0F0, 32'hFF00_FF00);
        drive("R3 or",  2'b10, 6'b100101, 3'b001, 32'hF0F0_F0F0, 32'h0F0F_0000);
        drive("R3 slt", 2'b10, 6'b101010, 3'b111, 32'hFFFF_FFFF, 32'h0000_0000);
        // R4: unlisted funct values.
        drive("R4", 2'b10, 6'b000000, 3'b011, 32'hDEAD_BEEF, 32'h1);
        drive("R4", 2'b10, 6'b100001, 3'b011, 32'hDEAD_BEEF, 32'h1);
        drive("R4", 2'b10, 6'b101011, 3'b011, 32'hDEAD_BEEF, 32'h1);
        // R5 / R8: logic ops with and without inverted B.
        drive("R5 and", 2'b00, 6'h0, 3'b000, 32'hAAAA_5555, 32'h5555_5555);
        drive("R5 or",  2'b00, 6'h0, 3'b001, 32'h0000_0000, 32'h0000_0000);
        drive("R8 andn", 2'b00, 6'h0, 3'b100, 32'hFFFF_FFFF, 32'h0F0F_0F0F);
        drive("R8 orn",  2'b00, 6'h0, 3'b101, 32'h0000_0000, 32'hFFFF_FFFF);
        drive("R8 orn",  2'b00, 6'h0, 3'b101, 32'h1234_0000, 32'h00FF_00FF);
        // R6: wrap to zero.
        drive("R6 wrap", 2'b00, 6'h0, 3'b010, 32'hFFFF_FFFF, 32'h0000_0001);
        // R7: equal operands and borrow.
        drive("R7 eq",  2'b01, 6'h0, 3'b110, 32'h8000_0000, 32'h8000_0000);
        drive("R7 neg", 2'b01, 6'h0, 3'b110, 32'h0000_0000, 32'h0000_0001);
        // R9: signed compare including overflow corners.
        drive("R9 ovf1", 2'b10, 6'b101010, 3'b111, 32'h8000_0000, 32'h0000_0001);
        drive("R9 ovf2", 2'b10, 6'b101010, 3'b111, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        drive("R9 eq",   2'b10, 6'b101010, 3'b111, 32'h0000_0005, 32'h0000_0005);
        drive("R9 pos",  2'b10, 6'b101010, 3'b111, 32'h0000_0004, 32'h0000_0005);
        drive("R9 ext",  2'b10, 6'b101010, 3'b111, 32'h8000_0000, 32'h7FFF_FFFF);
        // R10: unused code on nonzero operands.
        drive("R10", 2'b11, 6'h0, 3'b011, 32'hFFFF_FFFF, 32'hFFFF_FFFF);

        // Mixed sweep over all codes and classes (R1..R11).
        for (int i = 0; i < 400; i++) begin
            logic [W-1:0] x;
            logic [W-1:0] y;
            x = $urandom();
            y = (i % 5 == 0) ? x : $urandom();
            drive("R11 sweep", 2'(i % 4), 6'($urandom()), 3'(i % 8), x, y);
        end

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        report();
    end
endmodule